// File: doc/BRIEF.md
# Dual-format split-word shift-register store

This block is the sixteen-word state store for a datapath that runs one of two word-oriented stream ciphers at a time. It keeps every word as two independent 16-bit registers, so the store is thirty-two half-word registers rather than one array. A format input picks how a word maps onto its pair. In full format the pair holds the upper and lower halves of a 32-bit word. In 31-bit format the pair holds two overlapping 16-bit pieces, bits 30..15 and bits 15..0, which share bit 15.

Because the 31-bit pieces are kept apart, the 32-bit words that a nonlinear stage reads from the state are built by placing two stored pieces side by side, with no shifting or masking. The store moves every word one place towards the head on a shift step and takes a new tail word on a separate write strobe, so that a pipeline can shift in one stage and write the tail in a later one. The tail word has a second copy with its own output, so a second pipeline stage reads the tail without going through the read port. A parallel load writes all sixteen words at once during key and IV setup.

Top module: `dual_fmt_lfsr_store`

## Requirements
- R1: Synchronous active-high reset clears all thirty-two half registers, the tail copy, the read output and the four tap outputs to zero.
- R2: With `load_en` high, word i is taken from `load_bus[32*i +: 32]` for all sixteen words at the next edge; load wins over `shift_en` and `tail_we` in the same cycle.
- R3: With `fmt31` low a word w is kept as w[31:16] and w[15:0]; reading it back with `rd_idx` returns w unchanged, one cycle after `rd_idx` is applied.
- R4: With `fmt31` high a word w is kept as w[30:15] and w[15:0], so both pieces carry w[15]; read back it returns {1'b0, w[30:0]}, and w[31] is ignored.
- R5: With `shift_en` high (and no load), word i takes the old word i+1 for i = 0..14 at the next edge, and word 15 keeps its value when `tail_we` is low.
- R6: With `tail_we` high (and no load), word 15 takes `tail_word`; when `shift_en` is high in the same cycle, words 0..14 still shift and word 15 holds the new tail word.
- R7: With `fmt31` high the taps are registered concatenations: tap0 = {top(w15), bottom(w14)}, tap1 = {bottom(w11), top(w9)}, tap2 = {bottom(w7), top(w5)}, tap3 = {bottom(w2), top(w0)}, where top(w) = w[30:15] and bottom(w) = w[15:0].
- R8: With `fmt31` low the taps are the full words: tap0 = w15, tap1 = w11, tap2 = w5, tap3 = w0, registered one cycle after the state.
- R9: `tail_shadow` always equals word 15 read in the current format, updated in the same edge as word 15 by load or tail write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt31 | input | 1 | 1 = 31-bit overlapping format, 0 = full 32-bit format |
| load_en | input | 1 | Parallel load of all words |
| load_bus | input | 512 | Sixteen load words, word i at bits 32*i+31..32*i |
| shift_en | input | 1 | Move every word one place towards the head |
| tail_we | input | 1 | Write the tail word |
| tail_word | input | 32 | New value for the tail word |
| rd_idx | input | 4 | Word index for the read port |
| rd_word | output | 32 | Registered word selected by rd_idx |
| tap0 | output | 32 | Registered tap word 0 |
| tap1 | output | 32 | Registered tap word 1 |
| tap2 | output | 32 | Registered tap word 2 |
| tap3 | output | 32 | Registered tap word 3 |
| tail_shadow | output | 32 | Second copy of the tail word |

## Verification
The shift and the tail write can land in the same cycle, and the load can land on top of both. The bench walks a sequence of steps in each format whose strobe pattern rotates through shift alone, tail write alone, both together and idle, then issues a load with shift and tail write also high. After every step it reads all sixteen words, the four taps and the tail copy, and compares them with a word-level model that applies the shift and the tail write from the same old state, with load taking precedence.

// File: rtl/dfls_pkg.sv
package dfls_pkg;
  localparam int HALF_W = 16;
  localparam int NWORDS = 16;

  // Tap positions in full format (whole words)
  localparam int FULL_T0 = 15;
  localparam int FULL_T1 = 11;
  localparam int FULL_T2 = 5;
  localparam int FULL_T3 = 0;

  // Tap pairing in 31-bit format: first named piece is the upper half of the tap
  localparam int RG_T0_TOP = 15;
  localparam int RG_T0_BOT = 14;
  localparam int RG_T1_BOT = 11;
  localparam int RG_T1_TOP = 9;
  localparam int RG_T2_BOT = 7;
  localparam int RG_T2_TOP = 5;
  localparam int RG_T3_BOT = 2;
  localparam int RG_T3_TOP = 0;
endpackage

// File: rtl/dfls_half_cell.sv
module dfls_half_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_d,
  input  logic         wr,
  input  logic [W-1:0] wr_d,
  input  logic         sh,
  input  logic [W-1:0] sh_d,
  output logic [W-1:0] q
);
  // Priority: parallel load, then tail write, then shift
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= ld_d;
    else if (wr) q <= wr_d;
    else if (sh) q <= sh_d;
  end
endmodule

// File: rtl/dfls_word_split.sv
module dfls_word_split #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              fmt31,
  input  logic [WORD_W-1:0] word,
  output logic [HALF_W-1:0] hi,
  output logic [HALF_W-1:0] lo
);
  // 31-bit format: upper piece starts one bit lower so it overlaps the lower piece
  always_comb begin
    hi = fmt31 ? word[WORD_W-2 -: HALF_W] : word[WORD_W-1 -: HALF_W];
    lo = word[HALF_W-1:0];
  end
endmodule

// File: rtl/dfls_tap_read.sv
module dfls_tap_read
  import dfls_pkg::*;
#(
  parameter int HALF_W = dfls_pkg::HALF_W,
  parameter int NWORDS = dfls_pkg::NWORDS,
  localparam int WORD_W = 2 * HALF_W,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           fmt31,
  input  logic [NWORDS-1:0][HALF_W-1:0]  hi_q,
  input  logic [NWORDS-1:0][HALF_W-1:0]  lo_q,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [WORD_W-1:0]              rd_word,
  output logic [WORD_W-1:0]              tap0,
  output logic [WORD_W-1:0]              tap1,
  output logic [WORD_W-1:0]              tap2,
  output logic [WORD_W-1:0]              tap3
);
  function automatic logic [WORD_W-1:0] merge_halves(input logic f,
                                                    input logic [HALF_W-1:0] h,
                                                    input logic [HALF_W-1:0] l);
    merge_halves = f ? {1'b0, h, l[HALF_W-2:0]} : {h, l};
  endfunction

  logic [WORD_W-1:0] t0_n, t1_n, t2_n, t3_n;

  always_comb begin
    if (fmt31) begin
      t0_n = {hi_q[RG_T0_TOP], lo_q[RG_T0_BOT]};
      t1_n = {lo_q[RG_T1_BOT], hi_q[RG_T1_TOP]};
      t2_n = {lo_q[RG_T2_BOT], hi_q[RG_T2_TOP]};
      t3_n = {lo_q[RG_T3_BOT], hi_q[RG_T3_TOP]};
    end else begin
      t0_n = {hi_q[FULL_T0], lo_q[FULL_T0]};
      t1_n = {hi_q[FULL_T1], lo_q[FULL_T1]};
      t2_n = {hi_q[FULL_T2], lo_q[FULL_T2]};
      t3_n = {hi_q[FULL_T3], lo_q[FULL_T3]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
      tap0    <= '0;
      tap1    <= '0;
      tap2    <= '0;
      tap3    <= '0;
    end else begin
      rd_word <= merge_halves(fmt31, hi_q[rd_idx], lo_q[rd_idx]);
      tap0    <= t0_n;
      tap1    <= t1_n;
      tap2    <= t2_n;
      tap3    <= t3_n;
    end
  end
endmodule

// File: rtl/dual_fmt_lfsr_store.sv
module dual_fmt_lfsr_store #(
  parameter int HALF_W = dfls_pkg::HALF_W,
  parameter int NWORDS = dfls_pkg::NWORDS,
  localparam int WORD_W = 2 * HALF_W,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int TAIL = NWORDS - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fmt31,
  input  logic                     load_en,
  input  logic [NWORDS*WORD_W-1:0] load_bus,
  input  logic                     shift_en,
  input  logic                     tail_we,
  input  logic [WORD_W-1:0]        tail_word,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [WORD_W-1:0]        rd_word,
  output logic [WORD_W-1:0]        tap0,
  output logic [WORD_W-1:0]        tap1,
  output logic [WORD_W-1:0]        tap2,
  output logic [WORD_W-1:0]        tap3,
  output logic [WORD_W-1:0]        tail_shadow
);
  logic [NWORDS-1:0][HALF_W-1:0] hi_q, lo_q;
  logic [NWORDS-1:0][HALF_W-1:0] ld_hi, ld_lo;
  logic [HALF_W-1:0]             tw_hi, tw_lo;

  dfls_word_split #(.HALF_W(HALF_W)) u_tail_split (
    .fmt31(fmt31), .word(tail_word), .hi(tw_hi), .lo(tw_lo)
  );

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    dfls_word_split #(.HALF_W(HALF_W)) u_ld_split (
      .fmt31(fmt31), .word(load_bus[i*WORD_W +: WORD_W]),
      .hi(ld_hi[i]), .lo(ld_lo[i])
    );
    if (i == TAIL) begin : g_tail
      dfls_half_cell #(.W(HALF_W)) u_hi (
        .clk(clk), .rst(rst), .ld(load_en), .ld_d(ld_hi[i]),
        .wr(tail_we), .wr_d(tw_hi), .sh(1'b0), .sh_d('0), .q(hi_q[i])
      );
      dfls_half_cell #(.W(HALF_W)) u_lo (
        .clk(clk), .rst(rst), .ld(load_en), .ld_d(ld_lo[i]),
        .wr(tail_we), .wr_d(tw_lo), .sh(1'b0), .sh_d('0), .q(lo_q[i])
      );
    end else begin : g_body
      dfls_half_cell #(.W(HALF_W)) u_hi (
        .clk(clk), .rst(rst), .ld(load_en), .ld_d(ld_hi[i]),
        .wr(1'b0), .wr_d('0), .sh(shift_en), .sh_d(hi_q[i+1]), .q(hi_q[i])
      );
      dfls_half_cell #(.W(HALF_W)) u_lo (
        .clk(clk), .rst(rst), .ld(load_en), .ld_d(ld_lo[i]),
        .wr(1'b0), .wr_d('0), .sh(shift_en), .sh_d(lo_q[i+1]), .q(lo_q[i])
      );
    end
  end

  // Second copy of the tail, kept in word form for a direct read
  always_ff @(posedge clk) begin
    if (rst)
      tail_shadow <= '0;
    else if (load_en)
      tail_shadow <= fmt31 ? {1'b0, ld_hi[TAIL], ld_lo[TAIL][HALF_W-2:0]}
                           : {ld_hi[TAIL], ld_lo[TAIL]};
    else if (tail_we)
      tail_shadow <= fmt31 ? {1'b0, tw_hi, tw_lo[HALF_W-2:0]} : {tw_hi, tw_lo};
  end

  dfls_tap_read #(.HALF_W(HALF_W), .NWORDS(NWORDS)) u_taps (
    .clk(clk), .rst(rst), .fmt31(fmt31), .hi_q(hi_q), .lo_q(lo_q),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .tap0(tap0), .tap1(tap1), .tap2(tap2), .tap3(tap3)
  );
endmodule

// File: rtl/dfls_chk.sv
module dfls_chk #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              fmt31,
  input logic              load_en,
  input logic              shift_en,
  input logic              tail_we,
  input logic [HALF_W-1:0] load_tail_lo,
  input logic [HALF_W-1:0] hi_head,
  input logic [HALF_W-1:0] lo_head,
  input logic [HALF_W-1:0] hi_next,
  input logic [HALF_W-1:0] lo_next,
  input logic [HALF_W-1:0] hi_tail,
  input logic [HALF_W-1:0] lo_tail,
  input logic [HALF_W-1:0] lo_pretail,
  input logic [WORD_W-1:0] tap0,
  input logic [WORD_W-1:0] tail_shadow
);
  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> lo_tail == $past(load_tail_lo));

  // R5
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> (hi_head == $past(hi_next) && lo_head == $past(lo_next)));

  // R4
  mid_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (tail_we && fmt31 && !load_en) |=> hi_tail[0] == lo_tail[HALF_W-1]);

  // R9
  shadow_agree_chk: assert property (@(posedge clk) disable iff (rst)
    tail_shadow[HALF_W-1:0] == lo_tail);

  // R7
  tap_pair_chk: assert property (@(posedge clk) disable iff (rst)
    fmt31 |=> tap0 == $past({hi_tail, lo_pretail}));
endmodule

bind dual_fmt_lfsr_store dfls_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .fmt31(fmt31), .load_en(load_en),
  .shift_en(shift_en), .tail_we(tail_we),
  .load_tail_lo(load_bus[(NWORDS-1)*2*HALF_W +: HALF_W]),
  .hi_head(hi_q[0]), .lo_head(lo_q[0]),
  .hi_next(hi_q[1]), .lo_next(lo_q[1]),
  .hi_tail(hi_q[NWORDS-1]), .lo_tail(lo_q[NWORDS-1]),
  .lo_pretail(lo_q[NWORDS-2]),
  .tap0(tap0), .tail_shadow(tail_shadow)
);

// File: tb/dual_fmt_lfsr_store_bench.sv
module dual_fmt_lfsr_store_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fmt31 = 1'b0;
  logic         load_en = 1'b0;
  logic [511:0] load_bus = '0;
  logic         shift_en = 1'b0;
  logic         tail_we = 1'b0;
  logic [31:0]  tail_word = '0;
  logic [3:0]   rd_idx = '0;
  logic [31:0]  rd_word, tap0, tap1, tap2, tap3, tail_shadow;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] mdl [16];

  always #10 clk = ~clk;

  dual_fmt_lfsr_store u_dual_fmt_lfsr_store (
    .clk(clk), .rst(rst), .fmt31(fmt31), .load_en(load_en), .load_bus(load_bus),
    .shift_en(shift_en), .tail_we(tail_we), .tail_word(tail_word),
    .rd_idx(rd_idx), .rd_word(rd_word), .tap0(tap0), .tap1(tap1),
    .tap2(tap2), .tap3(tap3), .tail_shadow(tail_shadow)
  );

  function automatic logic [31:0] gen(input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E37_79B1;
    return v ^ (v >> 13) ^ {v[7:0], 24'h5A_C3_1F};
  endfunction

  function automatic logic [31:0] view(input logic [31:0] w);
    return fmt31 ? {1'b0, w[30:0]} : w;
  endfunction

  function automatic logic [15:0] top(input logic [31:0] w);
    return w[30:15];
  endfunction

  function automatic logic [15:0] bot(input logic [31:0] w);
    return w[15:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reads every word, then checks taps and tail copy against the model
  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      @(negedge clk);
      chk(req, $sformatf("word%0d", i), rd_word, view(mdl[i]));
    end
    if (fmt31) begin
      chk("R7", "tap0", tap0, {top(mdl[15]), bot(mdl[14])});
      chk("R7", "tap1", tap1, {bot(mdl[11]), top(mdl[9])});
      chk("R7", "tap2", tap2, {bot(mdl[7]), top(mdl[5])});
      chk("R7", "tap3", tap3, {bot(mdl[2]), top(mdl[0])});
    end else begin
      chk("R8", "tap0", tap0, mdl[15]);
      chk("R8", "tap1", tap1, mdl[11]);
      chk("R8", "tap2", tap2, mdl[5]);
      chk("R8", "tap3", tap3, mdl[0]);
    end
    chk("R9", "tail_shadow", tail_shadow, view(mdl[15]));
  endtask

  // One step; model applies shift and tail write from the same old state, load first
  task automatic step(input logic ld, input logic sh, input logic we,
                      input logic [31:0] tw);
    logic [31:0] nxt [16];
    @(negedge clk);
    load_en = ld; shift_en = sh; tail_we = we; tail_word = tw;
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      if (ld)                nxt[i] = load_bus[i*32 +: 32];
      else if (i == 15)      nxt[i] = we ? tw : mdl[15];
      else if (sh)           nxt[i] = mdl[i+1];
      else                   nxt[i] = mdl[i];
    end
    for (int i = 0; i < 16; i++) mdl[i] = nxt[i];
    @(negedge clk);
    load_en = 1'b0; shift_en = 1'b0; tail_we = 1'b0;
    chk("R9", "tail_shadow_same_edge", tail_shadow, view(mdl[15]));
  endtask

  task automatic run_phase(input int base);
    for (int i = 0; i < 16; i++) load_bus[i*32 +: 32] = gen(base + i);
    step(1'b1, 1'b0, 1'b0, '0);
    check_all(fmt31 ? "R4" : "R3");
    for (int s = 0; s < 24; s++) begin
      logic sh, we;
      sh = (s % 3) != 2;
      we = (s % 2) == 0;
      step(1'b0, sh, we, gen(base + 500 + s));
      // R5 shift only, R6 tail write alone or with shift
      check_all(we ? "R6" : "R5");
    end
    // R2 load together with shift and tail write: load wins
    for (int i = 0; i < 16; i++) load_bus[i*32 +: 32] = gen(base + 900 + i);
    step(1'b1, 1'b1, 1'b1, gen(base + 999));
    check_all("R2");
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1 outputs after reset, before any read
    chk("R1", "tap0_rst", tap0, '0);
    chk("R1", "tap3_rst", tap3, '0);
    chk("R1", "rd_rst", rd_word, '0);
    rst = 1'b0;
    check_all("R1");

    fmt31 = 1'b0;
    run_phase(100);
    @(negedge clk);
    fmt31 = 1'b1;
    run_phase(3000);
    // R4 bit 31 of a written word has no effect in 31-bit format
    step(1'b0, 1'b0, 1'b1, 32'hFFFF_0000);
    check_all("R4");
    step(1'b0, 1'b0, 1'b1, 32'h7FFF_0000);
    check_all("R4");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule